// File: doc/BRIEF.md
# Bus Machine-Cycle Sequencer

This block produces the external bus timing for one machine cycle of an 8-bit processor with a flat 64 KB address space. Code, data and stack all share that space. The core issues a request that names a cycle kind, a 16-bit address and, for writes, a data byte. For an opcode fetch the request also says whether the stretched form is needed. The sequencer accepts the request only while idle and then walks through the clock states of the cycle. It drives the address strobe, the memory/IO select line, the two status bits and the three active-low strobes for read, write and interrupt acknowledge. After the last state it raises a one-cycle done pulse and presents the byte it read.

Decoding instructions, choosing addressing modes and chaining the one to five machine cycles of an instruction all belong to the requester. An instruction always begins with an opcode fetch. In the halt cycle the block releases the select line and the read and write strobes. It signals this on a single output-enable line that the pad ring uses to float those pins. The data bus is split into an input, an output and an output enable.

Request kind codes: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 interrupt acknowledge, 6 halt.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset the block is idle with `ale_o`=0, `done_o`=0, `rd_n_o`=`wr_n_o`=`inta_n_o`=1, `s1_o`=`s0_o`=`io_m_o`=0, `ctl_oe_o`=1 and `dbus_oe_o`=0.
- R2: An opcode fetch (kind 0) without the long flag occupies exactly 4 states. During them it drives io_m=0, s1=1, s0=1 and, while its strobe is active, rd_n=0, wr_n=1, inta_n=1.
- R3: An opcode fetch with the long flag set occupies exactly 6 states with the same encoding as R2.
- R4: Memory read (kind 1) drives io_m=0, s1=1, s0=0 with rd_n low. Memory write (kind 2) drives io_m=0, s1=0, s0=1 with wr_n low. Each occupies 3 states when no wait is inserted.
- R5: I/O read (kind 3) drives io_m=1, s1=1, s0=0 with rd_n low. I/O write (kind 4) drives io_m=1, s1=0, s0=1 with wr_n low. Each occupies 3 states.
- R6: Interrupt acknowledge (kind 5) drives io_m=1, s1=1, s0=1 with inta_n low while rd_n and wr_n stay high. It occupies 3 states.
- R7: Halt (kind 6) occupies 3 states with s1=s0=0, inta_n=1 and `ctl_oe_o`=0, so the select line and the read and write strobes are floated. Halt ignores `ready_i`.
- R8: `ale_o` is high only in the first state of a cycle. `addr_o` equals the requested address in that state and holds it for the whole cycle.
- R9: For write kinds, `dbus_oe_o` is high and `dbus_o` carries the write byte from the second state through the final strobe state, and at no other time. Read kinds never raise `dbus_oe_o`.
- R10: For read kinds (0, 1, 3, 5), `rdata_o` holds the value of `dbus_i` at the clock edge that ends the last strobe state. Later changes of `dbus_i` do not affect it.
- R11: If `ready_i` is low at the edge ending the second state, wait states follow for as long as `ready_i` stays low. The strobes and status stay asserted through them, and the final strobe state follows the first edge at which `ready_i` is high.
- R12: `done_o` is high for exactly one cycle, immediately after the last state. Requests presented while a cycle is in progress are ignored, so the kind and address of the running cycle are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present; taken only when idle |
| req_kind_i | input | 3 | Cycle kind code |
| req_long_i | input | 1 | Opcode fetch uses the 6-state form |
| req_addr_i | input | 16 | Cycle address |
| req_wdata_i | input | 8 | Byte to write |
| ready_i | input | 1 | Slave ready; low stretches the cycle |
| dbus_i | input | 8 | Data bus input |
| addr_o | output | 16 | Address bus |
| ale_o | output | 1 | Address latch enable |
| io_m_o | output | 1 | 1 = I/O space, 0 = memory |
| s1_o | output | 1 | Status bit 1 |
| s0_o | output | 1 | Status bit 0 |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| inta_n_o | output | 1 | Interrupt acknowledge strobe, active low |
| ctl_oe_o | output | 1 | Drive enable for io_m, rd_n, wr_n pads |
| dbus_o | output | 8 | Data bus output |
| dbus_oe_o | output | 1 | Data bus drive enable |
| rdata_o | output | 8 | Byte captured by the last read cycle |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every cycle kind is run once with a fully ready bus, so the six status and strobe encodings and the three lengths (3, 4 and 6 states) are told apart state by state. Fetch, memory write and I/O read are repeated with `ready_i` held low for one or two edges. This separates correct wait insertion from strobes that drop early or from a cycle that ignores the slave. In the long fetch the data input is changed after the strobe ends, which exposes a capture taken at the wrong edge. In one memory read the request line stays high with a different kind and address while the cycle runs, which shows that busy-time requests are ignored.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        CK_FETCH  = 3'd0,
        CK_MEMRD  = 3'd1,
        CK_MEMWR  = 3'd2,
        CK_IORD   = 3'd3,
        CK_IOWR   = 3'd4,
        CK_INTACK = 3'd5,
        CK_HALT   = 3'd6
    } cyc_kind_e;

    typedef enum logic [3:0] {
        TS_IDLE, TS_T1, TS_T2, TS_TW, TS_T3, TS_T4, TS_T5, TS_T6, TS_DONE
    } tstate_e;

    typedef struct packed {
        logic io_m;
        logic s1;
        logic s0;
        logic rd_n;
        logic wr_n;
        logic inta_n;
    } busctl_t;

    localparam busctl_t CTL_IDLE = '{io_m: 1'b0, s1: 1'b0, s0: 1'b0,
                                     rd_n: 1'b1, wr_n: 1'b1, inta_n: 1'b1};

    // Line values while the strobe of the given kind is active.
    function automatic busctl_t kind_ctl(cyc_kind_e k);
        busctl_t c;
        c = CTL_IDLE;
        case (k)
            CK_FETCH:  c = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
            CK_MEMRD:  c = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
            CK_MEMWR:  c = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
            CK_IORD:   c = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
            CK_IOWR:   c = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
            CK_INTACK: c = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
            default:   c = CTL_IDLE;
        endcase
        return c;
    endfunction

    function automatic logic kind_reads(cyc_kind_e k);
        return (k == CK_FETCH) || (k == CK_MEMRD) || (k == CK_IORD) || (k == CK_INTACK);
    endfunction

    function automatic logic kind_writes(cyc_kind_e k);
        return (k == CK_MEMWR) || (k == CK_IOWR);
    endfunction

    function automatic logic in_strobe(tstate_e s);
        return (s == TS_T2) || (s == TS_TW) || (s == TS_T3);
    endfunction

    function automatic logic in_cycle(tstate_e s);
        return (s != TS_IDLE) && (s != TS_DONE);
    endfunction

endpackage

// File: rtl/bcs_tstate_fsm.sv
module bcs_tstate_fsm
    import bcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  cyc_kind_e kind_q,
    input  logic      long_q,
    input  logic      ready,
    output tstate_e   state,
    output logic      done
);

    tstate_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            TS_IDLE: if (start) nxt = TS_T1;
            TS_T1:   nxt = TS_T2;
            TS_T2:   nxt = (kind_q != CK_HALT && !ready) ? TS_TW : TS_T3;
            TS_TW:   if (ready) nxt = TS_T3;
            TS_T3:   nxt = (kind_q == CK_FETCH) ? TS_T4 : TS_DONE;
            TS_T4:   nxt = long_q ? TS_T5 : TS_DONE;
            TS_T5:   nxt = TS_T6;
            TS_T6:   nxt = TS_DONE;
            TS_DONE: nxt = TS_IDLE;
            default: nxt = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= TS_IDLE;
        else     state <= nxt;
    end

    assign done = (state == TS_DONE);

    // R12: completion lasts one cycle and returns to idle
    p_done_then_idle_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> (state == TS_IDLE));

    // R11: a wait state persists while the slave is not ready
    p_wait_holds_r11: assert property (@(posedge clk) disable iff (rst)
        (state == TS_TW && !ready) |=> (state == TS_TW));

    // R7: halt never waits
    p_halt_no_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (state == TS_T2 && kind_q == CK_HALT) |=> (state == TS_T3));

    // R2: short fetch ends after the fourth state
    p_short_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        (state == TS_T4 && !long_q) |=> done);

endmodule

// File: rtl/bcs_bus_lines.sv
module bcs_bus_lines
    import bcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tstate_e   state,
    input  cyc_kind_e kind_q,
    output logic      ale,
    output busctl_t   ctl,
    output logic      ctl_oe,
    output logic      strobe_on
);

    busctl_t full;

    always_comb begin
        full      = kind_ctl(kind_q);
        strobe_on = in_strobe(state);
        ctl       = CTL_IDLE;
        if (in_cycle(state)) begin
            ctl.io_m = full.io_m;
            ctl.s1   = full.s1;
            ctl.s0   = full.s0;
            if (strobe_on) begin
                ctl.rd_n   = full.rd_n;
                ctl.wr_n   = full.wr_n;
                ctl.inta_n = full.inta_n;
            end
        end
        ctl_oe = !(in_cycle(state) && kind_q == CK_HALT);
        ale    = (state == TS_T1);
    end

    // R8: address strobe lasts one state
    p_ale_single_r8: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    // R6: at most one strobe active at a time
    p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        $countones({~ctl.rd_n, ~ctl.wr_n, ~ctl.inta_n}) <= 1);

    // R11: strobes stay asserted from state to state inside the strobe window
    p_strobe_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (strobe_on && in_strobe(state)) |=> (!in_strobe(state) || $stable(ctl)));

endmodule

// File: rtl/bcs_data_path.sv
module bcs_data_path
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        req_kind,
    input  logic              req_long,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  tstate_e           state,
    input  logic              strobe_on,
    input  logic [DATA_W-1:0] dbus_in,
    output cyc_kind_e         kind_q,
    output logic              long_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] dbus_out,
    output logic              dbus_oe,
    output logic [DATA_W-1:0] rdata_q
);

    logic [DATA_W-1:0] wdata_q;
    logic              busy;

    assign busy = (state != TS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= CK_HALT;
            long_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                kind_q  <= cyc_kind_e'(req_kind);
                long_q  <= req_long;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state == TS_T3 && kind_reads(kind_q))
                rdata_q <= dbus_in;
        end
    end

    assign dbus_out = wdata_q;
    assign dbus_oe  = kind_writes(kind_q) && strobe_on;

    // R12: the request registers are frozen while a cycle runs
    p_req_frozen_r12: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(addr_q) && $stable(kind_q)));

    // R10: read data changes only on the edge ending the last strobe state
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (state != TS_T3) |=> $stable(rdata_q));

    // R9: the data bus is never driven on a read kind
    p_no_drive_on_read_r9: assert property (@(posedge clk) disable iff (rst)
        kind_reads(kind_q) |-> !dbus_oe);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [2:0]        req_kind_i,
    input  logic              req_long_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              ready_i,
    input  logic [DATA_W-1:0] dbus_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ale_o,
    output logic              io_m_o,
    output logic              s1_o,
    output logic              s0_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              inta_n_o,
    output logic              ctl_oe_o,
    output logic [DATA_W-1:0] dbus_o,
    output logic              dbus_oe_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o
);

    tstate_e   state;
    cyc_kind_e kind_q;
    logic      long_q;
    logic      start;
    logic      strobe_on;
    busctl_t   ctl;

    assign start = req_valid_i && (state == TS_IDLE);

    bcs_tstate_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .kind_q (kind_q),
        .long_q (long_q),
        .ready  (ready_i),
        .state  (state),
        .done   (done_o)
    );

    bcs_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_kind  (req_kind_i),
        .req_long  (req_long_i),
        .req_addr  (req_addr_i),
        .req_wdata (req_wdata_i),
        .state     (state),
        .strobe_on (strobe_on),
        .dbus_in   (dbus_i),
        .kind_q    (kind_q),
        .long_q    (long_q),
        .addr_q    (addr_o),
        .dbus_out  (dbus_o),
        .dbus_oe   (dbus_oe_o),
        .rdata_q   (rdata_o)
    );

    bcs_bus_lines u_lines (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .kind_q    (kind_q),
        .ale       (ale_o),
        .ctl       (ctl),
        .ctl_oe    (ctl_oe_o),
        .strobe_on (strobe_on)
    );

    assign io_m_o   = ctl.io_m;
    assign s1_o     = ctl.s1;
    assign s0_o     = ctl.s0;
    assign rd_n_o   = ctl.rd_n;
    assign wr_n_o   = ctl.wr_n;
    assign inta_n_o = ctl.inta_n;

    // R1: nothing strobes while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (state == TS_IDLE) |-> (rd_n_o && wr_n_o && inta_n_o && !dbus_oe_o));

    // R7: halt releases the control pads and keeps the status bits low
    p_halt_released_r7: assert property (@(posedge clk) disable iff (rst)
        !ctl_oe_o |-> (!s1_o && !s0_o && inta_n_o));

endmodule

// File: tb/sim_bus_cycle_seq.sv
`timescale 1ns/1ps
module sim_bus_cycle_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic        req_long = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready = 1'b1;
    logic [7:0]  dbus_in = '0;
    logic [15:0] addr_o;
    logic        ale_o, io_m_o, s1_o, s0_o, rd_n_o, wr_n_o, inta_n_o, ctl_oe_o;
    logic [7:0]  dbus_o, rdata_o;
    logic        dbus_oe_o, done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bus_cycle_seq u0 (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid), .req_kind_i(req_kind), .req_long_i(req_long),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ready_i(ready), .dbus_i(dbus_in),
        .addr_o(addr_o), .ale_o(ale_o), .io_m_o(io_m_o), .s1_o(s1_o), .s0_o(s0_o),
        .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .inta_n_o(inta_n_o), .ctl_oe_o(ctl_oe_o),
        .dbus_o(dbus_o), .dbus_oe_o(dbus_oe_o), .rdata_o(rdata_o), .done_o(done_o)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // {io_m, s1, s0, rd_n, wr_n, inta_n} with the strobe active
    function automatic logic [5:0] exp_ctl(logic [2:0] k);
        case (k)
            3'd0: return 6'b011_011;
            3'd1: return 6'b010_011;
            3'd2: return 6'b001_101;
            3'd3: return 6'b110_011;
            3'd4: return 6'b101_101;
            3'd5: return 6'b111_110;
            default: return 6'b000_111;
        endcase
    endfunction

    task automatic run_cycle(string tag, logic [2:0] k, logic lng, logic [15:0] a,
                             logic [7:0] wd, logic [7:0] rb, int w, bit hold_req);
        int len;
        int total;
        logic [5:0] e;
        bit rd_kind;
        bit wr_kind;
        len     = (k == 3'd0) ? (lng ? 6 : 4) : 3;
        total   = len + w;
        e       = exp_ctl(k);
        rd_kind = (k == 3'd0 || k == 3'd1 || k == 3'd3 || k == 3'd5);
        wr_kind = (k == 3'd2 || k == 3'd4);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_long = lng; req_addr = a;
        req_wdata = wd; dbus_in = rb; ready = 1'b1;
        for (int i = 0; i < total; i++) begin
            bit stb;
            @(negedge clk);
            stb = (i >= 1) && (i <= 2 + w);
            if (i == 0) begin
                if (hold_req) begin req_kind = 3'd2; req_addr = 16'hffff; req_long = 1'b1; end
                else req_valid = 1'b0;
            end
            chk({tag, " R8 ale"}, ale_o, (i == 0));
            chk({tag, " R8 addr"}, addr_o, a);
            chk({tag, " R12 done low"}, done_o, 0);
            chk({tag, " s1"}, s1_o, e[4]);
            chk({tag, " s0"}, s0_o, e[3]);
            chk({tag, " inta_n"}, inta_n_o, stb ? e[0] : 1'b1);
            if (k == 3'd6) begin
                chk({tag, " R7 ctl_oe"}, ctl_oe_o, 0);
            end else begin
                chk({tag, " ctl_oe"}, ctl_oe_o, 1);
                chk({tag, " io_m"}, io_m_o, e[5]);
                chk({tag, " rd_n"}, rd_n_o, stb ? e[2] : 1'b1);
                chk({tag, " wr_n"}, wr_n_o, stb ? e[1] : 1'b1);
            end
            chk({tag, " R9 dbus_oe"}, dbus_oe_o, wr_kind && stb);
            if (wr_kind && stb) chk({tag, " R9 dbus_o"}, dbus_o, wd);
            if (i == 1) ready = (w == 0);
            else if (i >= 2 && i <= 1 + w) ready = (i == 1 + w);
            if (i > 2 + w) dbus_in = ~rb;
        end
        @(negedge clk);
        req_valid = 1'b0;
        dbus_in = ~rb;
        chk({tag, " R12 done"}, done_o, 1);
        if (rd_kind) chk({tag, " R10 rdata"}, rdata_o, rb);
        chk({tag, " R1 ctl_oe after"}, ctl_oe_o, 1);
        chk({tag, " R1 strobes after"}, {rd_n_o, wr_n_o, inta_n_o}, 3'b111);
        chk({tag, " R8 ale after"}, ale_o, 0);
        @(negedge clk);
        chk({tag, " R12 done single"}, done_o, 0);
        if (rd_kind) chk({tag, " R10 rdata held"}, rdata_o, rb);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done", done_o, 0);
        chk("R1 ale", ale_o, 0);
        chk("R1 strobes", {rd_n_o, wr_n_o, inta_n_o}, 3'b111);
        chk("R1 status", {io_m_o, s1_o, s0_o}, 3'b000);
        chk("R1 ctl_oe", ctl_oe_o, 1);
        chk("R1 dbus_oe", dbus_oe_o, 0);
    endtask

    task automatic t_fetch();
        run_cycle("R2 fetch", 3'd0, 1'b0, 16'h2050, 8'h00, 8'h3e, 0, 1'b0);
        run_cycle("R3 fetch long", 3'd0, 1'b1, 16'h0100, 8'h00, 8'hc5, 0, 1'b0);
        run_cycle("R11 fetch wait", 3'd0, 1'b1, 16'h0101, 8'h00, 8'h7a, 2, 1'b0);
    endtask

    task automatic t_memory();
        run_cycle("R4 memrd", 3'd1, 1'b0, 16'hbeef, 8'h00, 8'h5a, 0, 1'b0);
        run_cycle("R4 memwr", 3'd2, 1'b0, 16'h8001, 8'ha5, 8'h00, 0, 1'b0);
        run_cycle("R11 memwr wait", 3'd2, 1'b0, 16'h0000, 8'h96, 8'h00, 1, 1'b0);
    endtask

    task automatic t_io();
        run_cycle("R5 iord", 3'd3, 1'b0, 16'h4242, 8'h00, 8'h81, 0, 1'b0);
        run_cycle("R5 iowr", 3'd4, 1'b0, 16'h1313, 8'h3c, 8'h00, 0, 1'b0);
        run_cycle("R11 iord wait", 3'd3, 1'b0, 16'h00ff, 8'h00, 8'he7, 2, 1'b0);
    endtask

    task automatic t_inta_halt();
        run_cycle("R6 intack", 3'd5, 1'b0, 16'h0038, 8'h00, 8'hcf, 0, 1'b0);
        run_cycle("R7 halt", 3'd6, 1'b0, 16'h0777, 8'h00, 8'h00, 0, 1'b0);
    endtask

    task automatic t_busy_ignore();
        run_cycle("R12 busy ignore", 3'd1, 1'b0, 16'h1234, 8'h00, 8'h69, 0, 1'b1);
        run_cycle("R12 back to back", 3'd0, 1'b0, 16'hfffe, 8'h00, 8'h11, 0, 1'b0);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fetch();
        t_memory();
        t_io();
        t_inta_halt();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule